// File: doc/BRIEF.md
# Multi-channel clock presence detector

This block watches eight external clocks that may appear or vanish at any time, for example when a cable carrying a video, audio or network clock is pulled out or plugged back in. Every monitored clock is compared against a free-running reference clock. A monitored clock that stops toggling is reported as gone. A clock that later starts toggling again is reported as back.

Each monitored clock drives a toggle flop in its own domain. That toggle is carried into the reference domain through a two-flop synchronizer, and a change detector there produces one pulse per monitored rising edge. An idle counter restarts on every pulse. A running clock is declared lost when the counter reaches the timeout. A lost clock must deliver several pulses in a row, with no timeout between them, before it is declared present again.

Every loss and every return sets a sticky per-channel flag, and software clears that flag by writing a one. The flags, gated by a per-channel enable, combine into one interrupt line to the processor. After reset every channel starts as lost, so the first running clock seen on a channel raises its restored flag.

Top module: `clkdet_top`

## Requirements
- R1: While reset is held and after it is released, with no monitored clock toggling, `present`, `lost_flag` and `restored_flag` are all zero and `irq` is low.
- R2: A present channel whose clock shows no rising edge for LOSS_TIMEOUT (default 64) reference cycles, plus synchronizer latency of at most 4 cycles, drops its `present` bit.
- R3: A present channel is never declared lost while its rising edges arrive less than LOSS_TIMEOUT reference cycles apart. It also stays present for at least 56 reference cycles after its clock stops.
- R4: A lost channel becomes present after RESTORE_EDGES (default 4) consecutive rising edges. A gap of LOSS_TIMEOUT cycles without an edge discards the edges counted so far, so a run of fewer than RESTORE_EDGES edges leaves the channel lost.
- R5: The cycle in which a channel becomes present, including the first detection after reset, sets its `restored_flag` bit.
- R6: The cycle in which a channel is declared lost sets its `lost_flag` bit. That bit sets only on a transition from present.
- R7: A one on bit i of `lost_ack` or `restored_ack` for one reference cycle clears the matching flag of channel i. Zero bits and bits of other channels leave the flags unchanged. A flag set in the same cycle as its acknowledge stays set.
- R8: `irq` is high exactly when some channel i has `lost_flag[i]` or `restored_flag[i]` set while `irq_en[i]` is one. An enable of zero suppresses that channel.
- R9: Channels are independent. Bit i of every vector port belongs to channel i, and the events on one channel never change the state or flags of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mon_clk | input | NUM_CH | Monitored clocks, one bit per channel, each asynchronous |
| irq_en | input | NUM_CH | Per-channel interrupt enable |
| lost_ack | input | NUM_CH | Write-one-to-clear for the lost flags |
| restored_ack | input | NUM_CH | Write-one-to-clear for the restored flags |
| present | output | NUM_CH | Channel currently judged to be running |
| lost_flag | output | NUM_CH | Sticky: channel went from present to lost |
| restored_flag | output | NUM_CH | Sticky: channel went from lost to present |
| irq | output | 1 | OR of enabled flags |

## Verification
The hardest case to reach from the ports is the discard of a partial restore run. The test has to leave a channel lost with fewer than the required edges counted, let a full timeout pass, and then show that a second short run still does not restore the channel. Only a single extra edge after that second run completes the count. The bench drives single pulses by hand on one channel to build exactly this history. It then lets free-running generators with random periods and random start and stop masks cover independent loss and return on all channels at once.

// File: rtl/clkdet_pkg.sv
package clkdet_pkg;

  localparam int unsigned DEF_NUM_CH        = 8;
  localparam int unsigned DEF_LOSS_TIMEOUT  = 64;
  localparam int unsigned DEF_RESTORE_EDGES = 4;

  typedef enum logic {
    CH_LOST    = 1'b0,
    CH_PRESENT = 1'b1
  } ch_state_e;

endpackage

// File: rtl/clkdet_rst_sync.sv
module clkdet_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/clkdet_edge_xfer.sv
// Toggle flop in the monitored domain, synchronizer and change detector
// in the reference domain. One output pulse per monitored rising edge.
module clkdet_edge_xfer #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic mon_clk,
  input  logic mon_rst_n,
  input  logic ref_clk,
  input  logic ref_rst_n,
  output logic edge_pulse
);

  logic              tog_q;
  logic              tog_d;
  logic [SYNC_STAGES-1:0] sync_q;
  logic              last_q;

  assign tog_d = ~tog_q;

  always_ff @(posedge mon_clk or negedge mon_rst_n) begin
    if (!mon_rst_n) tog_q <= 1'b0;
    else            tog_q <= tog_d;
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tog_q};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign edge_pulse = sync_q[SYNC_STAGES-1] ^ last_q;

endmodule

// File: rtl/clkdet_chan.sv
module clkdet_chan
  import clkdet_pkg::*;
#(
  parameter int unsigned LOSS_TIMEOUT  = DEF_LOSS_TIMEOUT,
  parameter int unsigned RESTORE_EDGES = DEF_RESTORE_EDGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_pulse,
  input  logic lost_ack,
  input  logic restored_ack,
  output logic present,
  output logic lost_flag,
  output logic restored_flag
);

  localparam int unsigned IDLE_W   = $clog2(LOSS_TIMEOUT + 1);
  localparam int unsigned RUN_W    = $clog2(RESTORE_EDGES + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(LOSS_TIMEOUT - 1);
  localparam logic [RUN_W-1:0]  RUN_LAST  = RUN_W'(RESTORE_EDGES - 1);

  ch_state_e         state_q, state_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic [RUN_W-1:0]  run_q, run_d;
  logic              lost_q, lost_d, lost_en;
  logic              rest_q, rest_d, rest_en;
  logic              expired;
  logic              set_lost, set_rest;

  // next state
  always_comb begin
    expired  = !edge_pulse && (idle_q == IDLE_LAST);
    state_d  = state_q;
    run_d    = run_q;
    set_lost = 1'b0;
    set_rest = 1'b0;

    if (edge_pulse || expired) idle_d = '0;
    else                       idle_d = idle_q + 1'b1;

    unique case (state_q)
      CH_PRESENT: begin
        run_d = '0;
        if (expired) begin
          state_d  = CH_LOST;
          set_lost = 1'b1;
        end
      end
      default: begin
        if (edge_pulse) begin
          if (run_q == RUN_LAST) begin
            state_d  = CH_PRESENT;
            set_rest = 1'b1;
            run_d    = '0;
          end else begin
            run_d = run_q + 1'b1;
          end
        end else if (expired) begin
          run_d = '0;
        end
      end
    endcase

    lost_en = set_lost | lost_ack;
    lost_d  = set_lost;
    rest_en = set_rest | restored_ack;
    rest_d  = set_rest;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_LOST;
      idle_q  <= '0;
      run_q   <= '0;
    end else begin
      state_q <= state_d;
      idle_q  <= idle_d;
      run_q   <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lost_q <= 1'b0;
    else if (lost_en) lost_q <= lost_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rest_q <= 1'b0;
    else if (rest_en) rest_q <= rest_d;
  end

  assign present       = (state_q == CH_PRESENT);
  assign lost_flag     = lost_q;
  assign restored_flag = rest_q;

endmodule

// File: rtl/clkdet_top.sv
module clkdet_top
  import clkdet_pkg::*;
#(
  parameter int unsigned NUM_CH        = DEF_NUM_CH,
  parameter int unsigned LOSS_TIMEOUT  = DEF_LOSS_TIMEOUT,
  parameter int unsigned RESTORE_EDGES = DEF_RESTORE_EDGES,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] mon_clk,
  input  logic [NUM_CH-1:0] irq_en,
  input  logic [NUM_CH-1:0] lost_ack,
  input  logic [NUM_CH-1:0] restored_ack,
  output logic [NUM_CH-1:0] present,
  output logic [NUM_CH-1:0] lost_flag,
  output logic [NUM_CH-1:0] restored_flag,
  output logic              irq
);

  logic              ref_rst_n;
  logic [NUM_CH-1:0] edge_pulse;

  clkdet_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (ref_clk),
    .rst_n     (rst_n),
    .rst_n_sync(ref_rst_n)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    clkdet_edge_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_xfer (
      .mon_clk   (mon_clk[ch]),
      .mon_rst_n (rst_n),
      .ref_clk   (ref_clk),
      .ref_rst_n (ref_rst_n),
      .edge_pulse(edge_pulse[ch])
    );

    clkdet_chan #(
      .LOSS_TIMEOUT (LOSS_TIMEOUT),
      .RESTORE_EDGES(RESTORE_EDGES)
    ) u_chan (
      .clk          (ref_clk),
      .rst_n        (ref_rst_n),
      .edge_pulse   (edge_pulse[ch]),
      .lost_ack     (lost_ack[ch]),
      .restored_ack (restored_ack[ch]),
      .present      (present[ch]),
      .lost_flag    (lost_flag[ch]),
      .restored_flag(restored_flag[ch])
    );
  end

  assign irq = |((lost_flag | restored_flag) & irq_en);

endmodule

// File: rtl/clkdet_checker.sv
module clkdet_checker #(
  parameter int unsigned NUM_CH = 8
) (
  input logic              ref_clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] lost_ack,
  input logic [NUM_CH-1:0] restored_ack,
  input logic [NUM_CH-1:0] present,
  input logic [NUM_CH-1:0] lost_flag,
  input logic [NUM_CH-1:0] restored_flag,
  input logic              irq
);

  AST_LOSS_SETS_FLAG: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (($past(present) & ~present & ~lost_flag) == '0)); // R6

  AST_LOST_FROM_PRESENT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ((lost_flag & ~$past(lost_flag) & (~$past(present) | present)) == '0)); // R6

  AST_RESTORE_SETS_FLAG: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ((~$past(present) & present & ~restored_flag) == '0)); // R5

  AST_RESTORED_FROM_LOST: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ((restored_flag & ~$past(restored_flag) & ($past(present) | ~present)) == '0)); // R5

  AST_LOST_CLEAR_BY_ACK: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (($past(lost_flag) & ~lost_flag & ~$past(lost_ack)) == '0)); // R7

  AST_REST_CLEAR_BY_ACK: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (($past(restored_flag) & ~restored_flag & ~$past(restored_ack)) == '0)); // R7

  AST_NO_FLAG_NO_IRQ: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ((lost_flag | restored_flag) == '0) |-> !irq); // R8

endmodule

bind clkdet_top clkdet_checker #(.NUM_CH(NUM_CH)) u_checker (
  .ref_clk      (ref_clk),
  .rst_n        (rst_n),
  .lost_ack     (lost_ack),
  .restored_ack (restored_ack),
  .present      (present),
  .lost_flag    (lost_flag),
  .restored_flag(restored_flag),
  .irq          (irq)
);

// File: tb/clkdet_top_test.sv
`timescale 1ns/1ps
module clkdet_top_test;

  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] mclk = '0;
  logic [NCH-1:0] irq_en = '0;
  logic [NCH-1:0] lost_ack = '0;
  logic [NCH-1:0] restored_ack = '0;
  logic [NCH-1:0] present;
  logic [NCH-1:0] lost_flag;
  logic [NCH-1:0] restored_flag;
  logic           irq;

  logic [NCH-1:0] run = '0;
  int             half [NCH];
  int             cnt  [NCH];
  int             checks = 0;
  int             fails = 0;
  bit             done = 1'b0;

  always #5 clk = ~clk;

  clkdet_top uut (
    .ref_clk      (clk),
    .rst_n        (rst_n),
    .mon_clk      (mclk),
    .irq_en       (irq_en),
    .lost_ack     (lost_ack),
    .restored_ack (restored_ack),
    .present      (present),
    .lost_flag    (lost_flag),
    .restored_flag(restored_flag),
    .irq          (irq)
  );

  // free-running monitored clock generators
  initial begin
    for (int i = 0; i < NCH; i++) begin half[i] = 3; cnt[i] = 0; end
    forever begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
        if (run[i]) begin
          cnt[i]++;
          if (cnt[i] >= half[i]) begin
            cnt[i] = 0;
            mclk[i] = ~mclk[i];
          end
        end
      end
    end
  end

  function automatic logic exp_irq(logic [NCH-1:0] lf, logic [NCH-1:0] rf,
                                   logic [NCH-1:0] en);
    return |((lf | rf) & en);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int ch, int n);
    repeat (n) begin
      @(negedge clk); mclk[ch] = 1'b1;
      cyc(3);         mclk[ch] = 1'b0;
      cyc(2);
    end
  endtask

  task automatic ack(logic [NCH-1:0] lm, logic [NCH-1:0] rm);
    @(negedge clk);
    lost_ack = lm; restored_ack = rm;
    @(negedge clk);
    lost_ack = '0; restored_ack = '0;
  endtask

  logic [NCH-1:0] prev, nrun, en;

  initial begin
    void'($urandom(32'h5EED_C10C));
    cyc(4);
    // R1: reset state, held and released, no clocks running
    check(present == '0 && lost_flag == '0 && restored_flag == '0 && !irq,
          "R1 during reset", {present, lost_flag, restored_flag}, 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(100);
    check(present == '0 && lost_flag == '0 && restored_flag == '0 && !irq,
          "R1 after reset", {present, lost_flag, restored_flag}, 0);

    // R4: partial run, timeout discards it, second partial run still lost
    pulse(3, 3);
    cyc(20);
    check(present[3] == 1'b0, "R4 three edges not enough", present, 0);
    cyc(80);
    pulse(3, 3);
    cyc(10);
    check(present[3] == 1'b0, "R4 run discarded after gap", present, 0);
    pulse(3, 1);
    cyc(6);
    check(present == 8'h08, "R4 fourth consecutive edge restores", present, 8'h08);
    check(restored_flag == 8'h08 && lost_flag == '0, "R5 restored flag set",
          restored_flag, 8'h08);
    half[3] = 3; run[3] = 1'b1;

    // R8: mask
    check(irq == 1'b0, "R8 masked channel", irq, 0);
    irq_en = 8'h08; #1;
    check(irq == exp_irq(lost_flag, restored_flag, irq_en), "R8 enabled channel", irq, 1);

    // R7: write-one-to-clear
    ack(8'h08, 8'h04);
    #1;
    check(restored_flag == 8'h08, "R7 other-bit ack ignored", restored_flag, 8'h08);
    ack('0, 8'h08);
    #1;
    check(restored_flag == '0 && !irq, "R7 ack clears flag", restored_flag, 0);

    // R3/R2/R6: loss timing on channel 3
    @(negedge clk); run[3] = 1'b0;
    cyc(56);
    check(present[3] == 1'b1, "R3 no loss before timeout", present, 8'h08);
    cyc(30);
    check(present[3] == 1'b0, "R2 loss after timeout", present, 0);
    check(lost_flag == 8'h08, "R6 lost flag set", lost_flag, 8'h08);
    #1;
    check(irq == 1'b1, "R8 loss interrupt", irq, 1);
    ack(8'h08, '0);
    #1;
    check(lost_flag == '0, "R7 lost flag cleared", lost_flag, 0);

    // R3: slow clock with edge gaps just under the timeout
    half[5] = 28; cnt[5] = 0; run[5] = 1'b1;
    cyc(400);
    check(present == 8'h20, "R3 slow clock stays present", present, 8'h20);
    check(lost_flag == '0, "R3 no loss on slow clock", lost_flag, 0);
    run[5] = 1'b0;
    cyc(120);
    ack('1, '1);
    cyc(2);
    check(present == '0 && lost_flag == '0 && restored_flag == '0,
          "R9 idle before random", {present, lost_flag}, 0);

    // R9: random independent start/stop patterns
    prev = '0;
    for (int ph = 0; ph < 14; ph++) begin
      ack('1, '1);
      nrun = NCH'($urandom);
      en   = NCH'($urandom);
      for (int i = 0; i < NCH; i++) if (!run[i]) begin
        half[i] = 2 + int'($urandom_range(4)); cnt[i] = 0;
      end
      @(negedge clk); run = nrun; irq_en = en;
      cyc(240);
      check(present == nrun, "R9 present pattern", present, nrun);
      check(lost_flag == (prev & ~nrun), "R6 random lost flags", lost_flag, prev & ~nrun);
      check(restored_flag == (~prev & nrun), "R5 random restored flags",
            restored_flag, ~prev & nrun);
      check(irq == exp_irq(prev & ~nrun, ~prev & nrun, en), "R8 random irq",
            irq, exp_irq(prev & ~nrun, ~prev & nrun, en));
      prev = nrun;
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule